// File: doc/BRIEF.md
# Programmable SRAM-Style Bus Cycle Controller

This block turns simple internal requests into bus cycles for a single external chip-select window. That window holds static RAM or burst-read ROM. A request carries a valid flag, a write flag, a physical address, byte enables, write data and, for burst reads, a count of extra beats. The controller answers each read beat with a data pulse and ends every request with a one-cycle done pulse.

On the device side the controller drives the following signals, all active low: the chip select, a read strobe that doubles as output enable, four byte write strobes and a bus-start marker. It also drives an offset address, write data with its drive enable, and samples an external ready line. Several timing inputs are sampled live and must stay stable while a request is in flight:
- the access wait count
- the address-to-strobe setup count
- the strobe-to-release hold count
- bus-start stretching
- the burst pitch
- the data width

Top module: `sram_cycle_ctrl`

## Requirements
- R1: A request whose address bits 28:26 equal 3'b010 runs a bus cycle. Any other request produces a done pulse in the cycle after acceptance, never asserts chip select and returns read data 0.
- R2: Chip select is low for exactly `cfg_setup` (0 to 7) cycles before any strobe goes low.
- R3: For a single access, the strobe stays low for `cfg_wait`+1 cycles. Any `cfg_wait` value above 25 is treated as 25.
- R4: When `cfg_wait` is nonzero and `bus_rdy` is sampled low at the end of the wait count, the strobe is held until the first rising edge at which `bus_rdy` is high. When `cfg_wait` is 0, `bus_rdy` has no effect.
- R5: Chip select stays low for exactly `cfg_hold` (0 to 7) cycles after the strobe rises.
- R6: A read lowers only `bus_rd_n`, and a write lowers only `bus_we_n` bits. Strobes only occur while chip select is low. `bus_doe` is high for every chip-select cycle of a write and for none of a read.
- R7: `bus_bs_n` is low in the first strobe cycle for one clock. It is low for two clocks when `cfg_bs_hold` is 1 and `cfg_setup` is at least 1.
- R8: Width code 2 (32-bit): `bus_we_n[i]` follows the inverse of `req_be[i]`, `bus_dout` carries all of the write data, and reads return `bus_din` unchanged.
- R9: Width code 1 (16-bit): address bit 1 selects a half. Strobes 0 and 1 follow byte enables {1,0} for half 0 or {3,2} for half 1, and strobes 2 and 3 stay high. The selected half is driven on `bus_dout[15:0]`, and reads return `bus_din[15:0]` zero-extended.
- R10: Width code 0 (8-bit): address bits 1:0 select a byte. Only strobe 0 is used, following that byte's enable. The byte is driven on `bus_dout[7:0]`, and reads return `bus_din[7:0]` zero-extended.
- R11: With `cfg_burst` set, a read performs `req_len` extra beats without raising the read strobe. Each extra beat lasts `cfg_pitch`+1 cycles and advances the address by the width in bytes. Every beat gives one `rsp_beat` pulse with its data, and `rsp_rdata` holds the last beat. Writes ignore `req_len`.
- R12: `req_ready` is high only when idle or in the done cycle, and never while chip select is low. Each request gives exactly one `rsp_done` pulse. After reset, all strobes and chip select are high and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept |
| req_write | input | 1 | 1 = write |
| req_addr | input | 29 | Physical address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| req_len | input | 2 | Extra burst beats |
| rsp_done | output | 1 | Request finished |
| rsp_beat | output | 1 | Read beat data valid |
| rsp_rdata | output | 32 | Read data |
| cfg_wait | input | 5 | Access wait count |
| cfg_setup | input | 3 | Setup cycles before strobe |
| cfg_hold | input | 3 | Hold cycles after strobe |
| cfg_bs_hold | input | 1 | Stretch bus-start |
| cfg_pitch | input | 3 | Burst beat wait count |
| cfg_width | input | 2 | 0=8, 1=16, 2=32 bit |
| cfg_burst | input | 1 | Burst ROM mode |
| bus_cs_n | output | 1 | Chip select |
| bus_rd_n | output | 1 | Read strobe / output enable |
| bus_we_n | output | 4 | Byte write strobes |
| bus_bs_n | output | 1 | Bus-start marker |
| bus_addr | output | 26 | Offset address in area |
| bus_dout | output | 32 | Write data |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 32 | Read data |
| bus_rdy | input | 1 | External ready |

## Verification
Some rules are checked by the in-line assertions on every cycle:
- strobes only appear inside chip select
- read and write strobes never overlap
- the unused lanes stay high in the narrow widths
- no request is taken while the bus is busy
- out-of-area requests finish at once with no chip select
- the ready-extension state is never entered with a zero wait count

Other behaviour depends on exact cycle counts and data values, so only the directed scenarios can show it. That covers the setup, strobe, hold and bus-start lengths, the stretching by ready, the clamping of the wait count, the byte-lane steering, and the burst beat timing and address advance.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int AW = 29,
  parameter int LEN_W = 2,
  parameter logic [2:0] AREA_ID = 3'b010,
  parameter int WAIT_MAX = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [3:0]       req_be,
  input  logic [31:0]      req_wdata,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_done,
  output logic             rsp_beat,
  output logic [31:0]      rsp_rdata,
  input  logic [4:0]       cfg_wait,
  input  logic [2:0]       cfg_setup,
  input  logic [2:0]       cfg_hold,
  input  logic             cfg_bs_hold,
  input  logic [2:0]       cfg_pitch,
  input  logic [1:0]       cfg_width,
  input  logic             cfg_burst,
  output logic             bus_cs_n,
  output logic             bus_rd_n,
  output logic [3:0]       bus_we_n,
  output logic             bus_bs_n,
  output logic [AW-4:0]    bus_addr,
  output logic [31:0]      bus_dout,
  output logic             bus_doe,
  input  logic [31:0]      bus_din,
  input  logic             bus_rdy
);
  localparam int OW = AW - 3;
  localparam logic [4:0] WMAX = WAIT_MAX[4:0];

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_EXTEND, S_HOLD, S_DONE} state_t;

  state_t           state;
  logic [4:0]       cnt;
  logic             wr_q, first_q, bsx_q, beat_q;
  logic [3:0]       be_q;
  logic [31:0]      wdata_q;
  logic [OW-1:0]    ofs_q;
  logic [LEN_W-1:0] left_q;

  logic [4:0]  wait_eff;
  logic        hit, accept, strobe_on, cs_on, beat_end;
  logic [1:0]  wsel;
  logic [3:0]  we_act;
  logic [31:0] dout_lane, rd_lane;
  logic [OW-1:0] step;

  assign wait_eff  = (cfg_wait > WMAX) ? WMAX : cfg_wait;
  assign hit       = (req_addr[AW-1 -: 3] == AREA_ID);
  assign req_ready = (state == S_IDLE) || (state == S_DONE);
  assign accept    = req_valid && req_ready;
  assign strobe_on = (state == S_STROBE) || (state == S_EXTEND);
  assign cs_on     = (state == S_SETUP) || strobe_on || (state == S_HOLD);
  assign beat_end  = ((state == S_STROBE) && (cnt == 5'd0) && ((wait_eff == 5'd0) || bus_rdy))
                   || ((state == S_EXTEND) && bus_rdy);
  assign wsel      = (cfg_width >= 2'd2) ? 2'd2 : cfg_width;
  assign step      = OW'(1) << wsel;

  always_comb begin
    case (wsel)
      2'd0: begin
        we_act    = {3'b000, be_q[ofs_q[1:0]]};
        dout_lane = {24'h0, wdata_q[{ofs_q[1:0], 3'b000} +: 8]};
        rd_lane   = {24'h0, bus_din[7:0]};
      end
      2'd1: begin
        we_act    = {2'b00, be_q[{ofs_q[1], 1'b0} +: 2]};
        dout_lane = {16'h0, wdata_q[{ofs_q[1], 4'b0000} +: 16]};
        rd_lane   = {16'h0, bus_din[15:0]};
      end
      default: begin
        we_act    = be_q;
        dout_lane = wdata_q;
        rd_lane   = bus_din;
      end
    endcase
  end

  assign bus_cs_n = !cs_on;
  assign bus_rd_n = !(strobe_on && !wr_q);
  assign bus_we_n = (strobe_on && wr_q) ? ~we_act : 4'hF;
  assign bus_bs_n = !((strobe_on && first_q) || bsx_q);
  assign bus_addr = ofs_q;
  assign bus_dout = dout_lane;
  assign bus_doe  = cs_on && wr_q;
  assign rsp_done = (state == S_DONE);
  assign rsp_beat = beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      first_q   <= 1'b0;
      bsx_q     <= 1'b0;
      beat_q    <= 1'b0;
      be_q      <= '0;
      wdata_q   <= '0;
      ofs_q     <= '0;
      left_q    <= '0;
      rsp_rdata <= '0;
    end else begin
      first_q <= 1'b0;
      bsx_q   <= first_q && strobe_on && cfg_bs_hold && (cfg_setup != 3'd0);
      beat_q  <= beat_end && !wr_q;
      if (beat_end && !wr_q) rsp_rdata <= rd_lane;
      case (state)
        S_IDLE, S_DONE: begin
          if (accept) begin
            wr_q      <= req_write;
            be_q      <= req_be;
            wdata_q   <= req_wdata;
            ofs_q     <= req_addr[OW-1:0];
            left_q    <= (cfg_burst && !req_write) ? req_len : '0;
            rsp_rdata <= '0;
            if (!hit) begin
              state <= S_DONE;
            end else if (cfg_setup != 3'd0) begin
              state <= S_SETUP;
              cnt   <= {2'b00, cfg_setup - 3'd1};
            end else begin
              state   <= S_STROBE;
              cnt     <= wait_eff;
              first_q <= 1'b1;
            end
          end else begin
            state <= S_IDLE;
          end
        end
        S_SETUP: begin
          if (cnt == 5'd0) begin
            state   <= S_STROBE;
            cnt     <= wait_eff;
            first_q <= 1'b1;
          end else begin
            cnt <= cnt - 5'd1;
          end
        end
        S_STROBE, S_EXTEND: begin
          if (beat_end) begin
            if (left_q != '0) begin
              left_q <= left_q - 1'b1;
              ofs_q  <= ofs_q + step;
              cnt    <= {2'b00, cfg_pitch};
              state  <= S_STROBE;
            end else if (cfg_hold != 3'd0) begin
              state <= S_HOLD;
              cnt   <= {2'b00, cfg_hold - 3'd1};
            end else begin
              state <= S_DONE;
            end
          end else if (state == S_STROBE) begin
            if (cnt != 5'd0) cnt <= cnt - 5'd1;
            else state <= S_EXTEND;
          end
        end
        S_HOLD: begin
          if (cnt == 5'd0) state <= S_DONE;
          else cnt <= cnt - 5'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_out_area_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (bus_cs_n && rsp_done));
  assert_ready_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXTEND) |-> (wait_eff != 5'd0));
  assert_strobe_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || (bus_we_n != 4'hF)) |-> !bus_cs_n);
  assert_rd_we_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && (bus_we_n != 4'hF)));
  assert_half_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_width == 2'd1) |-> (bus_we_n[3:2] == 2'b11));
  assert_byte_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_width == 2'd0) |-> (bus_we_n[3:1] == 3'b111));
  assert_no_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> !req_ready);
endmodule

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [28:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0] req_len = '0;
  logic [4:0] cfg_wait = '0;
  logic [2:0] cfg_setup = '0, cfg_hold = '0, cfg_pitch = '0;
  logic cfg_bs_hold = 0, cfg_burst = 0;
  logic [1:0] cfg_width = 2'd2;
  logic req_ready, rsp_done, rsp_beat, bus_cs_n, bus_rd_n, bus_bs_n, bus_doe;
  logic [31:0] rsp_rdata, bus_dout, bus_din;
  logic [3:0] bus_we_n;
  logic [25:0] bus_addr;
  logic bus_rdy = 1;

  int n_tests = 0, n_fail = 0, rdy_lat = 0;
  int m_cs = 0, m_rd = 0, m_bs = 0, m_pre = 0, m_post = 0, m_beat = 0, m_done = 0, m_doe = 0, m_busy = 0, scnt = 0;
  int m_we [4] = '{0, 0, 0, 0};
  int d_cs, d_rd, d_bs, d_pre, d_post, d_beat, d_done, d_doe, d_busy, lat;
  int d_we [4];
  logic seen = 0;
  logic [31:0] last_dout = '0;

  always #4 clk = ~clk;

  sram_cycle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_len(req_len), .rsp_done(rsp_done), .rsp_beat(rsp_beat), .rsp_rdata(rsp_rdata),
    .cfg_wait(cfg_wait), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_bs_hold(cfg_bs_hold),
    .cfg_pitch(cfg_pitch), .cfg_width(cfg_width), .cfg_burst(cfg_burst),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n), .bus_bs_n(bus_bs_n),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din), .bus_rdy(bus_rdy));

  function automatic logic [31:0] mem(input logic [25:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign bus_din = mem(bus_addr);

  always @(negedge clk) begin
    logic strb;
    strb = !bus_rd_n || (bus_we_n != 4'hF);
    if (!bus_cs_n) m_cs++;
    if (!bus_rd_n) m_rd++;
    if (!bus_bs_n) m_bs++;
    for (int i = 0; i < 4; i++) if (!bus_we_n[i]) m_we[i]++;
    if (bus_we_n != 4'hF) last_dout = bus_dout;
    if (rsp_beat) m_beat++;
    if (rsp_done) m_done++;
    if (bus_doe) m_doe++;
    if (!bus_cs_n && req_ready) m_busy++;
    if (bus_cs_n) seen = 0;
    else if (strb) seen = 1;
    else if (seen) m_post++;
    else m_pre++;
    if (strb) scnt++; else scnt = 0;
    bus_rdy <= (scnt >= rdy_lat);
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic set_cfg(input int w, input int s, input int h, input int bsh, input int p, input int wd, input int b);
    cfg_wait = 5'(w); cfg_setup = 3'(s); cfg_hold = 3'(h); cfg_bs_hold = bsh[0];
    cfg_pitch = 3'(p); cfg_width = 2'(wd); cfg_burst = b[0];
  endtask

  task automatic do_xfer(input logic wr, input logic [28:0] a, input logic [3:0] be, input logic [31:0] wd, input logic [1:0] len);
    int b_cs, b_rd, b_bs, b_pre, b_post, b_beat, b_done, b_doe, b_busy;
    int b_we [4];
    @(posedge clk); #2;
    b_cs = m_cs; b_rd = m_rd; b_bs = m_bs; b_pre = m_pre; b_post = m_post; b_beat = m_beat;
    b_done = m_done; b_doe = m_doe; b_busy = m_busy;
    for (int i = 0; i < 4; i++) b_we[i] = m_we[i];
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd; req_len = len;
    @(posedge clk); #2;
    req_valid = 0;
    lat = 1;
    while (!rsp_done && lat < 5000) begin
      @(posedge clk); #2;
      lat++;
    end
    if (lat >= 5000) check("watchdog request hung", lat, 0);
    @(negedge clk); #1;
    d_cs = m_cs - b_cs; d_rd = m_rd - b_rd; d_bs = m_bs - b_bs; d_pre = m_pre - b_pre;
    d_post = m_post - b_post; d_beat = m_beat - b_beat; d_done = m_done - b_done;
    d_doe = m_doe - b_doe; d_busy = m_busy - b_busy;
    for (int i = 0; i < 4; i++) d_we[i] = m_we[i] - b_we[i];
  endtask

  localparam logic [28:0] AREA = 29'h0800_0000;

  task automatic t_reset;
    check("R12 reset cs_n", int'(bus_cs_n), 1);
    check("R12 reset rd_n", int'(bus_rd_n), 1);
    check("R12 reset we_n", int'(bus_we_n), 15);
    check("R12 reset bs_n", int'(bus_bs_n), 1);
    check("R12 reset req_ready", int'(req_ready), 1);
    check("R12 reset rsp_done", int'(rsp_done), 0);
  endtask

  task automatic t_basic_read;
    set_cfg(3, 2, 1, 0, 0, 2, 0);
    do_xfer(0, AREA | 29'h40, 4'hF, 0, 0);
    check("R2 setup cycles", d_pre, 2);
    check("R3 strobe cycles", d_rd, 4);
    check("R5 hold cycles", d_post, 1);
    check("R2 total cs", d_cs, 7);
    check("R6 no write strobe on read", d_we[0] + d_we[1] + d_we[2] + d_we[3], 0);
    check("R6 no drive on read", d_doe, 0);
    check("R8 read data 32", int'(rsp_rdata), int'(mem(26'h40)));
    check("R12 one done", d_done, 1);
    check("R12 busy never ready", d_busy, 0);
  endtask

  task automatic t_zero_and_max;
    set_cfg(0, 0, 0, 0, 0, 2, 0);
    do_xfer(0, AREA | 29'h4, 4'hF, 0, 0);
    check("R2 zero setup", d_pre, 0);
    check("R3 zero wait strobe", d_rd, 1);
    check("R5 zero hold", d_post, 0);
    set_cfg(31, 7, 7, 0, 0, 2, 0);
    do_xfer(0, AREA | 29'h8, 4'hF, 0, 0);
    check("R3 wait clamp 25", d_rd, 26);
    check("R2 setup 7", d_pre, 7);
    check("R5 hold 7", d_post, 7);
  endtask

  task automatic t_ready;
    set_cfg(2, 1, 1, 0, 0, 2, 0);
    rdy_lat = 6;
    do_xfer(0, AREA | 29'h10, 4'hF, 0, 0);
    check("R4 ready stretch", d_rd, 6);
    check("R4 data after stretch", int'(rsp_rdata), int'(mem(26'h10)));
    set_cfg(0, 1, 1, 0, 0, 2, 0);
    do_xfer(0, AREA | 29'h10, 4'hF, 0, 0);
    check("R4 ready ignored at wait 0", d_rd, 1);
    set_cfg(3, 1, 1, 0, 0, 2, 0);
    rdy_lat = 2;
    do_xfer(0, AREA | 29'h10, 4'hF, 0, 0);
    check("R4 early ready no stretch", d_rd, 4);
    rdy_lat = 0;
  endtask

  task automatic t_bs;
    set_cfg(3, 2, 1, 1, 0, 2, 0);
    do_xfer(0, AREA, 4'hF, 0, 0);
    check("R7 bs stretched", d_bs, 2);
    set_cfg(3, 0, 1, 1, 0, 2, 0);
    do_xfer(0, AREA, 4'hF, 0, 0);
    check("R7 bs hold forced off", d_bs, 1);
    set_cfg(3, 2, 1, 0, 0, 2, 0);
    do_xfer(0, AREA, 4'hF, 0, 0);
    check("R7 bs single", d_bs, 1);
  endtask

  task automatic t_write32;
    set_cfg(1, 1, 1, 0, 0, 2, 0);
    do_xfer(1, AREA | 29'h20, 4'b0101, 32'hDEAD_BEEF, 0);
    check("R8 we0", d_we[0], 2);
    check("R8 we1 off", d_we[1], 0);
    check("R8 we2", d_we[2], 2);
    check("R8 we3 off", d_we[3], 0);
    check("R8 dout", int'(last_dout), int'(32'hDEAD_BEEF));
    check("R6 no read strobe on write", d_rd, 0);
    check("R6 drive during cs", d_doe, d_cs);
  endtask

  task automatic t_narrow;
    set_cfg(2, 0, 0, 0, 0, 1, 0);
    do_xfer(1, AREA | 29'h2, 4'b1000, 32'h1234_5678, 0);
    check("R9 we1 upper half", d_we[1], 3);
    check("R9 we0 off", d_we[0], 0);
    check("R9 we upper lanes off", d_we[2] + d_we[3], 0);
    check("R9 dout half", int'(last_dout), int'(32'h0000_1234));
    do_xfer(0, AREA | 29'h6, 4'hF, 0, 0);
    check("R9 read half zero-ext", int'(rsp_rdata), int'(32'h0000_FFF9));
    set_cfg(2, 0, 0, 0, 0, 0, 0);
    do_xfer(1, AREA | 29'h2, 4'b0100, 32'hA1B2_C3D4, 0);
    check("R10 we0 byte", d_we[0], 3);
    check("R10 other lanes off", d_we[1] + d_we[2] + d_we[3], 0);
    check("R10 dout byte", int'(last_dout), int'(32'h0000_00B2));
    do_xfer(0, AREA | 29'h3, 4'hF, 0, 0);
    check("R10 read byte zero-ext", int'(rsp_rdata), int'(32'h0000_00FC));
  endtask

  task automatic t_burst;
    set_cfg(2, 1, 1, 0, 1, 2, 1);
    do_xfer(0, AREA | 29'h100, 4'hF, 0, 3);
    check("R11 burst strobe length", d_rd, 9);
    check("R11 beat count", d_beat, 4);
    check("R11 last beat data", int'(rsp_rdata), int'(mem(26'h10C)));
    set_cfg(1, 0, 0, 0, 0, 1, 1);
    do_xfer(0, AREA | 29'h20, 4'hF, 0, 1);
    check("R11 16-bit burst length", d_rd, 3);
    check("R11 16-bit advance", int'(rsp_rdata), int'(32'h0000_FFDD));
    set_cfg(1, 0, 0, 0, 2, 2, 1);
    do_xfer(1, AREA | 29'h30, 4'hF, 32'h5, 3);
    check("R11 write ignores len", d_we[0], 2);
    check("R11 write no beats", d_beat, 0);
  endtask

  task automatic t_out_area;
    set_cfg(3, 2, 2, 0, 0, 2, 0);
    do_xfer(0, 29'h0C00_0040, 4'hF, 0, 0);
    check("R1 no chip select", d_cs, 0);
    check("R1 done next cycle", lat, 1);
    check("R1 read data zero", int'(rsp_rdata), 0);
    check("R1 one done", d_done, 1);
  endtask

  initial begin
    #(8 * 200000);
    check("watchdog expired", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset;
    rst_n = 1;
    @(posedge clk); #2;
    t_reset;
    t_basic_read;
    t_zero_and_max;
    t_ready;
    t_bs;
    t_write32;
    t_narrow;
    t_burst;
    t_out_area;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule